// File: doc/BRIEF.md
# MSI Doorbell to SPI Pulse Frame

This block is a small memory-mapped register frame that converts message-signalled interrupt writes into interrupt line pulses. A device that wants to raise an interrupt writes an absolute interrupt ID into a doorbell register. The frame rebases that ID against the window of shared peripheral interrupt lines it owns. If the ID falls inside that window, the frame drives a one-cycle pulse on the matching output line. IDs outside the window are discarded without any side effect.

The frame occupies a 4 KB window and is little-endian. Its slave port is a plain 32-bit register bus with a byte-size qualifier and separate read and write strobes. Software learns the window from a read-only type register and identifies the frame through a fixed identification word. Two parameters set the window: the first SPI number it owns, and how many lines it drives. The parameters are checked when the design is elaborated.

Top module: `msi_spi_frame`

## Requirements
- R1: While `rst` is high, `irq_pulse` is all zero and `bus_rdata` is zero in the cycle that follows, whatever the bus does.
- R2: A 4-byte read at offset 0x008 returns `((BASE_SPI + 32) << 16) | SPI_COUNT` on `bus_rdata` in the cycle after the read strobe (0x00200040 with default parameters).
- R3: A 4-byte read at offset 0xFCC returns 0x05100000: product code 0x51 in bits 27:20, with every other field zero.
- R4: A 4-byte read at any offset from 0xFD0 to 0xFFC, or at any offset that is not mapped, returns zero.
- R5: A read whose `bus_size` is not 4 returns zero. In every cycle that follows a cycle without a read strobe, `bus_rdata` is zero.
- R6: A write at offset 0x040 takes the ID from data bits 9:0. When BASE_SPI + 32 <= ID < BASE_SPI + 32 + SPI_COUNT, the write raises `irq_pulse[ID - BASE_SPI - 32]` in the cycle after the write, and no other line rises.
- R7: A doorbell ID below BASE_SPI + 32, or at or above BASE_SPI + 32 + SPI_COUNT, leaves every line low. Data bits 31:10 play no part in the decode.
- R8: A doorbell write takes effect only when `bus_size` is 2 or 4. Any other size is ignored.
- R9: A write to any offset other than 0x040 has no effect on `irq_pulse` or on what later reads return.
- R10: Each accepted doorbell write produces a pulse exactly one cycle long. Two writes to the same ID with an idle cycle between them produce two separate pulses. Writes on consecutive cycles keep the line high for one cycle per write.
- R11: The configuration is legal only if SPI_COUNT is between 1 and 128 and BASE_SPI + 32 <= 1020 - SPI_COUNT. An illegal configuration is reported at elaboration, and under it `irq_pulse` stays low. The boundary BASE_SPI = 860, SPI_COUNT = 128 is legal, and ID 1019 reaches line 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset inside the 4 KB frame |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_pulse | output | SPI_COUNT | One-cycle interrupt pulses, bit 0 is the first owned SPI |

## Verification
The bench aims at the two edges of the ID window: the lowest and highest IDs that hit, and the IDs just outside on each side. An off-by-one in the rebase would shift or drop a pulse there. It writes IDs with junk in the upper data bits, where a decoder that uses too many bits would miss. It sends wrong-size reads and writes, where a frame that ignores the size would leak the type value or fire a line. It also writes to the type register, where a decoder with loose address matching would fire a pulse or change the value read back. Back-to-back and spaced repeats to one ID expose a pulse stretcher that merges events or holds a line high. A second instance at the largest legal base catches range arithmetic that overflows near ID 1020.

// File: rtl/msi_frame_pkg.sv
`timescale 1ns/1ps
package msi_frame_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int ID_W     = 10;
    localparam int SPI_OFFS = 32;
    localparam int ID_LIMIT = 1020;
    localparam int MAX_LINES = 128;

    localparam logic [ADDR_W-1:0] OFF_TYPE     = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_DOORBELL = 12'h040;
    localparam logic [ADDR_W-1:0] OFF_IDENT    = 12'hFCC;
    localparam logic [ADDR_W-1:0] OFF_ZERO_LO  = 12'hFD0;
    localparam logic [ADDR_W-1:0] OFF_ZERO_HI  = 12'hFFC;

    localparam logic [7:0] PRODUCT_CODE = 8'h51;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_TYPE,
        SEL_IDENT,
        SEL_ZERO
    } rd_sel_e;

    typedef struct packed {
        logic    rd_ok;
        rd_sel_e sel;
        logic    ring;
    } access_t;

    function automatic bit cfg_legal(input int base, input int count);
        return (count >= 1) && (count <= MAX_LINES) &&
               (base >= 0) && (base + SPI_OFFS <= ID_LIMIT - count);
    endfunction

    function automatic logic [DATA_W-1:0] type_word(input int base, input int count);
        logic [DATA_W-1:0] w;
        w = '0;
        w[31:16] = 16'(base + SPI_OFFS);
        w[15:0]  = 16'(count);
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] ident_word();
        logic [DATA_W-1:0] w;
        w = '0;
        w[27:20] = PRODUCT_CODE;
        return w;
    endfunction

endpackage

// File: rtl/msi_frame_decode.sv
`timescale 1ns/1ps
module msi_frame_decode
    import msi_frame_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        size_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output access_t           acc_o
);

    logic rd_size_ok;
    logic wr_size_ok;

    always_comb begin
        rd_size_ok = (size_i == 3'd4);
        wr_size_ok = (size_i == 3'd2) || (size_i == 3'd4);

        acc_o       = '0;
        acc_o.rd_ok = rd_i && rd_size_ok;
        acc_o.ring  = wr_i && wr_size_ok && (addr_i == OFF_DOORBELL);

        if (addr_i == OFF_TYPE) begin
            acc_o.sel = SEL_TYPE;
        end else if (addr_i == OFF_IDENT) begin
            acc_o.sel = SEL_IDENT;
        end else if (addr_i >= OFF_ZERO_LO && addr_i <= OFF_ZERO_HI) begin
            acc_o.sel = SEL_ZERO;
        end else begin
            acc_o.sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/msi_frame_readback.sv
`timescale 1ns/1ps
module msi_frame_readback
    import msi_frame_pkg::*;
#(
    parameter int BASE_SPI  = 0,
    parameter int SPI_COUNT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [DATA_W-1:0] TYPE_VAL  = type_word(BASE_SPI, SPI_COUNT);
    localparam logic [DATA_W-1:0] IDENT_VAL = ident_word();

    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (acc_i.rd_ok) begin
            unique case (acc_i.sel)
                SEL_TYPE:  rd_next = TYPE_VAL;
                SEL_IDENT: rd_next = IDENT_VAL;
                default:   rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_o <= '0;
        else     rdata_o <= rd_next;
    end

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !acc_i.rd_ok |=> (rdata_o == '0));

endmodule

// File: rtl/msi_doorbell.sv
`timescale 1ns/1ps
module msi_doorbell
    import msi_frame_pkg::*;
#(
    parameter int BASE_SPI  = 0,
    parameter int SPI_COUNT = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ring_i,
    input  logic [ID_W-1:0]      id_i,
    output logic [SPI_COUNT-1:0] pulse_o
);

    localparam int  CALC_W = ID_W + 2;
    localparam int  WIN_LO = BASE_SPI + SPI_OFFS;
    localparam int  WIN_HI = WIN_LO + SPI_COUNT;
    localparam bit  CFG_OK = cfg_legal(BASE_SPI, SPI_COUNT);

    logic [CALC_W-1:0]    id_ext;
    logic [CALC_W-1:0]    rel;
    logic                 in_win;
    logic [SPI_COUNT-1:0] hit;

    assign id_ext = CALC_W'(id_i);
    assign in_win = (id_ext >= CALC_W'(WIN_LO)) && (id_ext < CALC_W'(WIN_HI));
    assign rel    = id_ext - CALC_W'(WIN_LO);

    for (genvar g = 0; g < SPI_COUNT; g++) begin : g_line
        assign hit[g] = ring_i && in_win && (rel == CALC_W'(g));

        always_ff @(posedge clk) begin
            if (rst) pulse_o[g] <= 1'b0;
            else     pulse_o[g] <= CFG_OK && hit[g];
        end
    end

    initial begin
        assert_cfg_legal_R11: assert (CFG_OK)
            else $error("msi_doorbell: BASE_SPI=%0d SPI_COUNT=%0d is not a legal window",
                        BASE_SPI, SPI_COUNT);
    end

    assert_pulse_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulse_o));

    assert_pulse_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        ((pulse_o != '0) && !ring_i) |=> (pulse_o == '0));

    assert_no_pulse_without_ring_R7: assert property (@(posedge clk) disable iff (rst)
        !ring_i |=> (pulse_o == '0));

endmodule

// File: rtl/msi_spi_frame.sv
`timescale 1ns/1ps
module msi_spi_frame
    import msi_frame_pkg::*;
#(
    parameter int BASE_SPI  = 0,
    parameter int SPI_COUNT = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic [2:0]           bus_size,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    output logic [31:0]          bus_rdata,
    output logic [SPI_COUNT-1:0] irq_pulse
);

    access_t acc;

    msi_frame_decode u_decode (
        .addr_i (bus_addr),
        .size_i (bus_size),
        .rd_i   (bus_rd),
        .wr_i   (bus_wr),
        .acc_o  (acc)
    );

    msi_frame_readback #(
        .BASE_SPI  (BASE_SPI),
        .SPI_COUNT (SPI_COUNT)
    ) u_readback (
        .clk     (clk),
        .rst     (rst),
        .acc_i   (acc),
        .rdata_o (bus_rdata)
    );

    msi_doorbell #(
        .BASE_SPI  (BASE_SPI),
        .SPI_COUNT (SPI_COUNT)
    ) u_doorbell (
        .clk     (clk),
        .rst     (rst),
        .ring_i  (acc.ring),
        .id_i    (bus_wdata[ID_W-1:0]),
        .pulse_o (irq_pulse)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> ((irq_pulse == '0) && (bus_rdata == '0)));

    assert_bad_read_size_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_size != 3'd4) |=> (bus_rdata == '0));

    assert_bad_write_size_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_size != 3'd2 && bus_size != 3'd4) |=> (irq_pulse == '0));

    assert_other_offset_write_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != 12'h040) |=> (irq_pulse == '0));

endmodule

// File: tb/test_msi_spi_frame.sv
`timescale 1ns/1ps
module test_msi_spi_frame;

    localparam int B  = 0;
    localparam int N  = 64;
    localparam int EB = 860;
    localparam int EN = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [2:0]  size = 3'd4;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] rdata;
    logic [N-1:0] pulse;

    logic [11:0]  e_addr = '0;
    logic [31:0]  e_wdata = '0;
    logic [2:0]   e_size = 3'd4;
    logic         e_rd = 1'b0;
    logic         e_wr = 1'b0;
    logic [31:0]  e_rdata;
    logic [EN-1:0] e_pulse;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0]  rdata;
        logic [N-1:0] pulse;
        string        tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    msi_spi_frame #(.BASE_SPI(B), .SPI_COUNT(N)) i_msi_spi_frame (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata), .bus_size(size),
        .bus_rd(rd), .bus_wr(wr), .bus_rdata(rdata), .irq_pulse(pulse)
    );

    msi_spi_frame #(.BASE_SPI(EB), .SPI_COUNT(EN)) i_msi_spi_frame_edge (
        .clk(clk), .rst(rst), .bus_addr(e_addr), .bus_wdata(e_wdata), .bus_size(e_size),
        .bus_rd(e_rd), .bus_wr(e_wr), .bus_rdata(e_rdata), .irq_pulse(e_pulse)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic r, input logic [11:0] a,
                                             input logic [2:0] s);
        if (!r || s != 3'd4) return 32'h0;
        if (a == 12'h008) return ((32'(B) + 32) << 16) | 32'(N);
        if (a == 12'hFCC) return 32'h51 << 20;
        return 32'h0;
    endfunction

    function automatic logic [N-1:0] model_pulse(input logic w, input logic [11:0] a,
                                                 input logic [2:0] s, input logic [31:0] d);
        int id;
        logic [N-1:0] v;
        v = '0;
        id = int'(d[9:0]);
        if (w && a == 12'h040 && (s == 3'd2 || s == 3'd4) &&
            id >= B + 32 && id < B + 32 + N)
            v[id - B - 32] = 1'b1;
        return v;
    endfunction

    task automatic bus_op(input logic r, input logic w, input logic [11:0] a,
                          input logic [2:0] s, input logic [31:0] d, input string tag);
        exp_t it;
        @(negedge clk);
        rd = r; wr = w; addr = a; size = s; wdata = d;
        it.rdata = model_rd(r, a, s);
        it.pulse = model_pulse(w, a, s, d);
        it.tag   = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input string tag);
        bus_op(1'b0, 1'b0, 12'h000, 3'd4, 32'h0, tag);
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check(rdata == it.rdata, it.tag, 128'(rdata), 128'(it.rdata));
            check(pulse == it.pulse, it.tag, 128'(pulse), 128'(it.pulse));
        end
    end

    task automatic e_cycle(input logic r, input logic w, input logic [11:0] a,
                           input logic [31:0] d);
        @(negedge clk);
        e_rd = r; e_wr = w; e_addr = a; e_size = 3'd4; e_wdata = d;
        @(negedge clk);
        e_rd = 1'b0; e_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: doorbell and read during reset stay silent
        @(negedge clk);
        rd = 1'b1; wr = 1'b1; addr = 12'h040; size = 3'd4; wdata = 32'd40;
        @(negedge clk);
        check(pulse == '0, "R1 pulse in reset", 128'(pulse), 128'h0);
        check(rdata == '0, "R1 rdata in reset", 128'(rdata), 128'h0);
        check(e_pulse == '0, "R1 edge pulse in reset", 128'(e_pulse), 128'h0);
        rd = 1'b0; wr = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        idle("R5 idle");
        bus_op(1, 0, 12'h008, 3'd4, 0, "R2 type read");
        bus_op(1, 0, 12'h008, 3'd2, 0, "R5 type read size2");
        bus_op(1, 0, 12'h008, 3'd1, 0, "R5 type read size1");
        bus_op(1, 0, 12'hFCC, 3'd4, 0, "R3 ident read");
        bus_op(1, 0, 12'hFD0, 3'd4, 0, "R4 id block low");
        bus_op(1, 0, 12'hFE8, 3'd4, 0, "R4 id2");
        bus_op(1, 0, 12'hFFC, 3'd4, 0, "R4 id block high");
        bus_op(1, 0, 12'h00C, 3'd4, 0, "R4 unmapped");
        bus_op(1, 0, 12'h009, 3'd4, 0, "R4 misaligned type");
        idle("R5 idle");
        bus_op(0, 1, 12'h040, 3'd4, 32'd32, "R6 lowest id");
        idle("R10 after pulse");
        bus_op(0, 1, 12'h040, 3'd4, 32'd95, "R6 highest id");
        bus_op(0, 1, 12'h040, 3'd4, 32'd61, "R6 mid id");
        bus_op(0, 1, 12'h040, 3'd2, 32'd50, "R8 size2 write");
        bus_op(0, 1, 12'h040, 3'd1, 32'd50, "R8 size1 write");
        bus_op(0, 1, 12'h040, 3'd3, 32'd50, "R8 size3 write");
        bus_op(0, 1, 12'h040, 3'd4, 32'd31, "R7 below window");
        bus_op(0, 1, 12'h040, 3'd4, 32'd96, "R7 above window");
        bus_op(0, 1, 12'h040, 3'd4, 32'hFFFF_FC28, "R7 upper bits ignored");
        bus_op(0, 1, 12'h040, 3'd4, 32'd1023, "R7 max id");
        bus_op(0, 1, 12'h008, 3'd4, 32'd40, "R9 write type reg");
        bus_op(0, 1, 12'h044, 3'd4, 32'd40, "R9 write near doorbell");
        bus_op(1, 0, 12'h008, 3'd4, 0, "R9 type unchanged");
        bus_op(0, 1, 12'h040, 3'd4, 32'd40, "R10 first of pair");
        bus_op(0, 1, 12'h040, 3'd4, 32'd40, "R10 second of pair");
        idle("R10 gap");
        bus_op(0, 1, 12'h040, 3'd4, 32'd40, "R10 spaced first");
        idle("R10 gap");
        bus_op(0, 1, 12'h040, 3'd4, 32'd40, "R10 spaced second");
        bus_op(1, 1, 12'h040, 3'd4, 32'd33, "R6 read and ring together");
        idle("R10 tail");
        idle("R5 tail");
        @(negedge clk);
        @(negedge clk);

        // R11: largest legal window, type word and the last line
        e_cycle(1, 0, 12'h008, 0);
        check(e_rdata == 32'h037C_0080, "R11 edge type", 128'(e_rdata), 128'h037C0080);
        @(negedge clk);
        e_wr = 1'b1; e_addr = 12'h040; e_size = 3'd4; e_wdata = 32'd1019;
        @(negedge clk);
        e_wr = 1'b0;
        check(e_pulse == (128'h1 << 127), "R11 edge id 1019", 128'(e_pulse), 128'h1 << 127);
        @(negedge clk);
        check(e_pulse == '0, "R11 edge pulse ends", 128'(e_pulse), 128'h0);
        e_wr = 1'b1; e_wdata = 32'd892;
        @(negedge clk);
        e_wr = 1'b0;
        check(e_pulse == 128'h1, "R11 edge id 892", 128'(e_pulse), 128'h1);
        e_wr = 1'b1; e_wdata = 32'd891;
        @(negedge clk);
        e_wr = 1'b0;
        check(e_pulse == '0, "R11 edge id 891", 128'(e_pulse), 128'h0);
        @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule